// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM with an 18-bit address. The host presents one command at a time, either a read or a write, with a request strobe. The controller then drives the RAM's active-low chip-enable, output-enable and write-enable pins as a timed sequence. It holds the address and the write data steady for the whole cycle. For a read it captures the returned byte and reports it to the host with a one-cycle valid pulse.

Every RAM timing limit is a nanosecond parameter: access time, output-enable access, minimum cycle time, write pulse width, data setup, data hold and write recovery. Each phase length is the matching limit divided by the clock period and rounded up. A write is a single pulse in which chip-enable and write-enable are low together. Write-enable rises first, ending the write, while chip-enable and the data stay in place for a hold phase. Output-enable stays high for the whole write. A write-inhibit input protects the memory at once. It forces every strobe inactive, aborts any cycle in progress and blocks new commands until it clears.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, ce, oe and we are all high, dq_oe_o and rvalid_o are low, and ready_o is high after reset when inhibit is low.
- R2: A read holds ce and oe low and we high for RD_CYC consecutive cycles, where RD_CYC = ceil(max(access 70 ns, oe access 35 ns, cycle 70 ns) / CLK_NS). This gives 9 cycles at 8 ns. The byte on dq_i at the clock edge that ends the last cycle appears on rdata_o while rvalid_o is high. rvalid_o is high for exactly one cycle, directly after the strobes return high.
- R3: A write holds ce and we low together for WP_CYC = ceil(max(pulse 55 ns, setup 30 ns) / CLK_NS) cycles. It then holds ce low and we high for WH_CYC = max(1, ceil(max(hold, recovery 5 ns) / CLK_NS), ceil(70 ns / CLK_NS) - WP_CYC) cycles. At 8 ns these are 7 and 2. oe stays high, and dq_oe_o stays high, for all of these cycles.
- R4: sram_addr_o stays constant for every cycle in which ce is low. sram_dq_o stays constant while dq_oe_o is high. Both hold the values the host gave when the command was accepted.
- R5: ready_o is high only when no cycle is in progress and inhibit is low. A command is accepted on a clock edge where req_i and ready_o are both high. Otherwise req_i has no effect on the strobes or on the memory contents.
- R6: At least one cycle with ce high and dq_oe_o low separates any two operations. dq_oe_o is never high while oe is low, and it is low in the cycle before oe falls.
- R7: While inhibit_i is high, ce, we and oe are high, dq_oe_o and ready_o are low, and these take effect without waiting for a clock edge. A cycle in progress is dropped, no byte is written and no rvalid_o pulse follows.
- R8: Read results come back in command order, and each one equals the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Command address |
| wdata_i | input | 8 | Write byte |
| inhibit_i | input | 1 | Write protect / abort |
| ready_o | output | 1 | Idle and able to accept a command |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | rdata_o valid, one-cycle pulse |
| sram_addr_o | output | 18 | RAM address |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_o | output | 8 | Data driven toward the RAM |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 8 | Data returned from the RAM |

## Verification
The bench runs against a behavioural RAM. That RAM returns a poison byte until both the 70 ns and 35 ns access windows have elapsed, and it rejects write pulses shorter than 55 ns or with under 30 ns of setup. A read phase one cycle too short therefore shows up as a wrong byte, and a write phase one cycle too short shows up as a timing error. The stimulus includes extreme addresses, alternating bit patterns, and a read issued directly after a write to the same address, which checks data ordering and the turnaround gap. A walk of eight writes with read-back, an unwritten location, and inhibit raised while idle, mid-write and mid-read separate protection and abort faults from ordinary timing faults.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WPULSE, ST_WHOLD} cyc_state_e;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/100ps
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_data_hold.sv
`timescale 1ns/100ps
module sram_data_hold #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sample_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (accept_i) begin
      addr_o <= addr_i;
      dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= sample_i;
      if (sample_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/100ps
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 8,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_RC_NS  = 70,
  parameter int T_WP_NS  = 55,
  parameter int T_DS_NS  = 30,
  parameter int T_DH_NS  = 0,
  parameter int T_WR_NS  = 5,
  parameter int T_WC_NS  = 70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          inhibit_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int RD_CYC  = imax(imax(cyc_ceil(T_ACC_NS, CLK_NS), cyc_ceil(T_OE_NS, CLK_NS)),
                                cyc_ceil(T_RC_NS, CLK_NS));
  localparam int WP_CYC  = imax(cyc_ceil(T_WP_NS, CLK_NS), cyc_ceil(T_DS_NS, CLK_NS));
  localparam int WH_CYC  = imax(imax(1, cyc_ceil(imax(T_DH_NS, T_WR_NS), CLK_NS)),
                                cyc_ceil(T_WC_NS, CLK_NS) - WP_CYC);
  localparam int MAX_CYC = imax(RD_CYC, imax(WP_CYC, WH_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  cyc_state_e    state_q, state_d;
  logic          accept, load, sample, expired;
  logic [CW-1:0] load_val;

  assign ready_o = (state_q == ST_IDLE) && !inhibit_i;
  assign accept  = req_i && ready_o;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    sample   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          load = 1'b1;
          if (we_i) begin
            state_d  = ST_WPULSE;
            load_val = CW'(WP_CYC - 1);
          end else begin
            state_d  = ST_READ;
            load_val = CW'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (inhibit_i) state_d = ST_IDLE;
        else if (expired) begin
          sample  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WPULSE: begin
        if (inhibit_i) state_d = ST_IDLE;
        else if (expired) begin
          state_d  = ST_WHOLD;
          load     = 1'b1;
          load_val = CW'(WH_CYC - 1);
        end
      end
      ST_WHOLD: begin
        if (inhibit_i || expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  sram_data_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .sample_i (sample),
    .dq_i     (sram_dq_i),
    .addr_o   (sram_addr_o),
    .dq_o     (sram_dq_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  // inhibit gates the pins directly so protection does not wait for a clock edge
  assign sram_ce_no   = (state_q == ST_IDLE) || inhibit_i;
  assign sram_oe_no   = (state_q != ST_READ) || inhibit_i;
  assign sram_we_no   = (state_q != ST_WPULSE) || inhibit_i;
  assign sram_dq_oe_o = ((state_q == ST_WPULSE) || (state_q == ST_WHOLD)) && !inhibit_i;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/100ps
module sram_cycle_ctrl_chk #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          inhibit_i,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_ce_no,
  input logic          sram_oe_no,
  input logic          sram_we_no,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> sram_we_no); // R3
  AST_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no); // R6
  AST_OE_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_oe_no && $past(sram_oe_no)) |-> !$past(sram_dq_oe_o)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o)); // R4
  AST_WDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o)); // R4
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R2
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (sram_ce_no && !$past(sram_oe_no))); // R2
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && !sram_dq_oe_o)); // R5
  AST_INHIBIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> (sram_ce_no && sram_we_no && sram_oe_no && !ready_o && !sram_dq_oe_o)); // R7
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/100ps
module sram_cycle_ctrl_bench;
  localparam int  CLK_NS = 8;
  localparam int  RD_EXP = 9;  // ceil(70/8)
  localparam int  WP_EXP = 7;  // ceil(55/8)
  localparam int  WH_EXP = 2;  // max(1, ceil(70/8) - 7)
  localparam logic [7:0] POISON = 8'h5C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, inhibit = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [17:0] s_addr;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] shadow[int];
  logic [7:0] ram[int];
  bit abort_run = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_NS(CLK_NS)) u_sram_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .inhibit_i(inhibit), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .sram_addr_o(s_addr), .sram_ce_no(ce_n),
    .sram_oe_no(oe_n), .sram_we_no(we_n), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // behavioural RAM: poison until access windows elapse; checks write pulse timing
  real t_addr = 0.0, t_ce = 0.0, t_oe = 0.0, t_dq = 0.0, t_wp = 0.0;
  bit  in_wp = 1'b0;
  always @(s_addr)        t_addr = $realtime;
  always @(negedge ce_n)  t_ce = $realtime;
  always @(negedge oe_n)  t_oe = $realtime;
  always @(dq_o)          t_dq = $realtime;

  always @(ce_n or we_n) begin
    if (!ce_n && !we_n && !in_wp) begin
      in_wp = 1'b1;
      t_wp  = $realtime;
    end else if (in_wp && (ce_n || we_n)) begin
      in_wp = 1'b0;
      if (!inhibit) begin
        chk($realtime - t_wp >= 55.0, "R3", "write pulse ns", longint'($realtime - t_wp), 55);
        chk($realtime - t_dq >= 30.0, "R3", "data setup ns", longint'($realtime - t_dq), 30);
        chk(dq_oe, "R3", "data driven at write end", longint'(dq_oe), 1);
        ram[int'(s_addr)] = dq_o;
      end
    end
  end

  initial begin
    dq_i = POISON;
    #0.5;
    forever begin
      real now;
      now = $realtime;
      if (!ce_n && !oe_n && we_n && (now - t_addr >= 70.0) && (now - t_ce >= 70.0)
          && (now - t_oe >= 35.0))
        dq_i = ram.exists(int'(s_addr)) ? ram[int'(s_addr)] : 8'h00;
      else
        dq_i = POISON;
      #1;
    end
  end

  // strobe-shape and scoreboard monitor
  int ce_run = 0, we_run = 0, oe_run = 0;
  logic [17:0] run_addr;
  logic prev_dq_oe = 1'b0, prev_oe_n = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n && prev_oe_n)
        chk(!prev_dq_oe, "R6", "dq_oe released before oe", longint'(prev_dq_oe), 0);
      if (!ce_n) begin
        if (ce_run == 0) run_addr = s_addr;
        else if (s_addr != run_addr) chk(1'b0, "R4", "address moved", s_addr, run_addr);
        ce_run++;
        if (!we_n) we_run++;
        if (!oe_n) oe_run++;
        if (oe_run == 0 && !abort_run && !dq_oe)
          chk(1'b0, "R3", "dq_oe in write", 0, 1);
      end else if (ce_run != 0) begin
        if (!abort_run) begin
          if (oe_run != 0) begin
            chk(ce_run == RD_EXP && oe_run == RD_EXP && we_run == 0, "R2",
                "read strobe cycles", ce_run, RD_EXP);
          end else begin
            chk(we_run == WP_EXP, "R3", "we low cycles", we_run, WP_EXP);
            chk(ce_run == WP_EXP + WH_EXP, "R3", "ce low cycles", ce_run, WP_EXP + WH_EXP);
          end
        end
        chk(!dq_oe, "R6", "bus free in gap", longint'(dq_oe), 0);
        ce_run = 0; we_run = 0; oe_run = 0;
      end
      if (rvalid) begin
        if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected rvalid", 1, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R8", "read data", rdata, e);
        end
      end
      prev_dq_oe = dq_oe;
      prev_oe_n  = oe_n;
    end
  end

  task automatic issue(input bit w, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    if (w) shadow[int'(a)] = d;
    else   exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !ready) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #20;
    chk(ce_n && oe_n && we_n, "R1", "strobes in reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(!dq_oe && !rvalid, "R1", "bus/valid in reset", {dq_oe, rvalid}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R1", "ready after reset", longint'(ready), 1);

    issue(1, 18'h00000, 8'h11);
    issue(1, 18'h3FFFF, 8'hA5);
    issue(1, 18'h15555, 8'h3C);
    issue(1, 18'h2AAAA, 8'hC3);
    issue(0, 18'h3FFFF, 8'h00);
    issue(0, 18'h00000, 8'h00);
    issue(0, 18'h2AAAA, 8'h00);
    issue(0, 18'h15555, 8'h00);
    issue(1, 18'h00100, 8'h7E);
    issue(0, 18'h00100, 8'h00);  // read right after write, same address
    issue(0, 18'h01234, 8'h00);  // never written
    for (int i = 0; i < 8; i++) issue(1, 18'(i * 18'h08001), 8'(i * 29 + 3));
    for (int i = 7; i >= 0; i--) issue(0, 18'(i * 18'h08001), 8'h00);
    drain();

    // R7/R5: inhibit while idle, request must be ignored
    issue(1, 18'h00003, 8'hA6);
    drain();
    @(negedge clk); inhibit = 1'b1;
    @(negedge clk);
    chk(!ready && ce_n, "R7", "idle under inhibit", {ready, ce_n}, 2'b01);
    req = 1'b1; we = 1'b1; addr = 18'h00003; wdata = 8'h5A;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ce_n && we_n && !ready, "R5", "req ignored", {ce_n, we_n, ready}, 3'b110);
    end
    req = 1'b0;
    @(negedge clk); inhibit = 1'b0;
    issue(0, 18'h00003, 8'h00);  // must still read A6
    drain();

    // R7: abort a write in progress
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 18'h00009; wdata = 8'h77;
    @(negedge clk); req = 1'b0;
    repeat (2) @(negedge clk);
    #2; abort_run = 1'b1; inhibit = 1'b1;
    #1;
    chk(ce_n && we_n && !dq_oe, "R7", "write aborted at once", {ce_n, we_n, dq_oe}, 3'b110);
    repeat (3) begin
      @(negedge clk);
      chk(!ready && ce_n, "R7", "ready held low", {ready, ce_n}, 2'b01);
    end
    inhibit = 1'b0;
    @(negedge clk); abort_run = 1'b0;
    issue(0, 18'h00009, 8'h00);  // aborted write left no byte
    drain();

    // R7: abort a read in progress, no rvalid may follow
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 18'h00003;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    #2; abort_run = 1'b1; inhibit = 1'b1;
    #1;
    chk(ce_n && oe_n, "R7", "read aborted at once", {ce_n, oe_n}, 2'b11);
    repeat (2) @(negedge clk);
    inhibit = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (rvalid) seen++;
      end
      chk(seen == 0, "R7", "no rvalid after abort", seen, 0);
    end
    abort_run = 1'b0;
    issue(0, 18'h00003, 8'h00);
    drain();

    chk(exp_q.size() == 0, "R8", "all reads returned", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule